// File: doc/BRIEF.md
# Bipolar Line Code Encoder (HDB3 / B8ZS / AMI)

This block turns a single-rail NRZ bit stream into a pair of bipolar pulse requests, one rail for positive marks and one for negative marks, for a line driver that follows it. Each new bit is announced by a one-cycle strobe. Two static inputs pick the line code. A code-select bit of 0 gives zero substitution, which is HDB3 on an E1 line and B8ZS on a T1 line. A code-select bit of 1 gives plain alternate mark inversion on either line type.

Zero substitution must rewrite a run of zeros starting at its first bit, before the run is known to be long enough. The block therefore holds incoming bits in a short delay line and emits each bit only once the full run window behind it is visible. A substitution sequencer then decides whether the emitted bit is a plain data symbol or one position of a substitution pattern. A polarity tracker turns each symbol into a pulse on the correct rail.

When dual-rail format is selected, the encoder is bypassed. The two input rails are copied to the outputs on each strobe, and all encoder state is cleared so that coding restarts cleanly when single-rail format returns.

Top module: `line_encoder`

## Requirements
- R1: After reset, both output rails are low. The encoder starts with the last-mark polarity negative and an even (zero) mark count since the last violation, so the first mark sent is on the positive rail.
- R2: While `dual_rail` is 1, each strobe copies `rail_p_in`/`rail_n_in` to `line_p`/`line_n` at the next clock edge. Every clock edge with `dual_rail` at 1 clears the delay line, the substitution sequencer and the polarity state to their reset values.
- R3: With `code_ami`=0 and `sel_t1`=0 (HDB3), each run of four zeros is sent as B00V when the count of marks since the last violation is even, and as 000V when it is odd. B is a pulse opposite in polarity to the preceding pulse. V repeats the polarity of the preceding pulse. Two consecutive pulses of the same polarity occur only at a V.
- R4: With `code_ami`=0 and `sel_t1`=1 (B8ZS), each run of eight zeros is sent as 000VB0VB relative to the polarity of the preceding pulse.
- R5: With `code_ami`=1, every 1 becomes a pulse opposite in polarity to the previous pulse, and every 0 gives no pulse on either rail, whatever the length of the zero run.
- R6: The output produced at strobe k+L encodes the bit given at strobe k. L is 4 in HDB3 mode and 8 in B8ZS and AMI modes. The first L strobes after reset or after leaving dual-rail produce no pulse.
- R7: In single-rail mode, the two output rails are never high together.
- R8: The outputs change only on the clock edge that samples a strobe. A cycle without a strobe leaves both rails unchanged.
- R9: In HDB3 mode, successive violation pulses alternate in polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe marking a new bit period |
| tx_bit | input | 1 | Single-rail NRZ data bit, sampled with the strobe |
| rail_p_in | input | 1 | Positive rail input, used in dual-rail mode |
| rail_n_in | input | 1 | Negative rail input, used in dual-rail mode |
| dual_rail | input | 1 | 1 selects dual-rail pass-through, 0 selects single-rail coding |
| code_ami | input | 1 | 1 selects plain AMI, 0 selects zero substitution |
| sel_t1 | input | 1 | 1 selects the T1 substitution (B8ZS), 0 selects E1 (HDB3) |
| line_p | output | 1 | Positive mark request |
| line_n | output | 1 | Negative mark request |

## Verification
The hardest case to reach is HDB3 with an odd mark count when a run starts, because that is the only case that produces 000V. The same case is what makes violation polarity alternate. Uniform random data seldom gives long zero runs after a controlled number of marks. The stimulus therefore biases zeros to about three in four, and it also drives directed runs of back-to-back zero blocks and isolated marks. This exercises both parities and chained substitutions many times. Segments are separated by a short dual-rail interval. This restarts coding from a known state and also exercises the clearing behaviour.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

  localparam int unsigned HDB_RUN = 4;
  localparam int unsigned B8_RUN  = 8;
  localparam int unsigned POS_W   = $clog2(B8_RUN);

  typedef enum logic [1:0] {
    SYM_SPACE = 2'd0,
    SYM_MARK  = 2'd1,
    SYM_BAL   = 2'd2,
    SYM_VIOL  = 2'd3
  } sym_kind_e;

  // Symbol kind at a given position of a substitution pattern.
  function automatic sym_kind_e subst_kind(input logic t1, input logic even,
                                           input logic [POS_W-1:0] pos);
    sym_kind_e k;
    k = SYM_SPACE;
    if (t1) begin
      case (pos)
        3'd3, 3'd6: k = SYM_VIOL;
        3'd4, 3'd7: k = SYM_BAL;
        default:    k = SYM_SPACE;
      endcase
    end else begin
      if (pos == 3'd0 && even) k = SYM_BAL;
      else if (pos == 3'd3)    k = SYM_VIOL;
      else                     k = SYM_SPACE;
    end
    return k;
  endfunction

  // Polarity (1 = positive) of a pulse given the previous pulse polarity.
  function automatic logic pulse_pol(input sym_kind_e k, input logic last_pos);
    return (k == SYM_VIOL) ? last_pos : ~last_pos;
  endfunction

  // Mark parity since last violation after emitting symbol k.
  function automatic logic next_odd(input sym_kind_e k, input logic odd);
    logic r;
    case (k)
      SYM_VIOL:          r = 1'b0;
      SYM_MARK, SYM_BAL: r = ~odd;
      default:           r = odd;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lenc_delay.sv
module lenc_delay #(
  parameter int unsigned DEPTH = lenc_pkg::B8_RUN,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift,
  input  logic          din,
  input  logic [IW-1:0] tap_idx,
  output logic          tap_bit,
  output logic          tap_vld,
  output logic          win_zero
);

  logic [DEPTH-1:0] dat_q;
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      dat_q <= '0;
      vld_q <= '0;
    end else if (shift) begin
      dat_q <= {dat_q[DEPTH-2:0], din};
      vld_q <= {vld_q[DEPTH-2:0], 1'b1};
    end
  end

  assign tap_bit = dat_q[tap_idx];
  assign tap_vld = vld_q[tap_idx];

  // All stages from the newest up to the tap hold valid zeros.
  always_comb begin
    win_zero = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (i <= int'(tap_idx)) begin
        if (dat_q[i] || !vld_q[i]) win_zero = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lenc_subst.sv
module lenc_subst
  import lenc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      adv,
  input  logic      use_sub,
  input  logic      t1,
  input  logic      even,
  input  logic      tap_bit,
  input  logic      tap_vld,
  input  logic      win_zero,
  output sym_kind_e kind,
  output logic      sub_start,
  output logic      sub_busy
);

  logic [POS_W-1:0] pos_q;
  logic             busy_q;
  logic [POS_W-1:0] last_pos;

  assign last_pos  = t1 ? POS_W'(B8_RUN - 1) : POS_W'(HDB_RUN - 1);
  assign sub_busy  = busy_q;
  assign sub_start = !busy_q && use_sub && tap_vld && !tap_bit && win_zero;

  always_comb begin
    if (busy_q)                  kind = subst_kind(t1, even, pos_q);
    else if (sub_start)          kind = subst_kind(t1, even, '0);
    else if (tap_vld && tap_bit) kind = SYM_MARK;
    else                         kind = SYM_SPACE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (adv) begin
      if (busy_q) begin
        if (pos_q >= last_pos) begin
          busy_q <= 1'b0;
          pos_q  <= '0;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end else if (sub_start) begin
        busy_q <= 1'b1;
        pos_q  <= POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/lenc_pol.sv
module lenc_pol
  import lenc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      adv,
  input  logic      dual,
  input  logic      rail_p,
  input  logic      rail_n,
  input  sym_kind_e kind,
  output logic      even,
  output logic      out_p,
  output logic      out_n,
  output logic      viol_q,
  output logic      coded_q
);

  logic last_pos_q;
  logic odd_q;
  logic is_pulse;
  logic pol;

  assign is_pulse = (kind != SYM_SPACE);
  assign pol      = pulse_pol(kind, last_pos_q);
  assign even     = ~odd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      last_pos_q <= 1'b0;
      odd_q      <= 1'b0;
    end else if (adv) begin
      if (is_pulse) last_pos_q <= pol;
      odd_q <= next_odd(kind, odd_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_p   <= 1'b0;
      out_n   <= 1'b0;
      viol_q  <= 1'b0;
      coded_q <= 1'b0;
    end else if (adv) begin
      if (dual) begin
        out_p   <= rail_p;
        out_n   <= rail_n;
        viol_q  <= 1'b0;
        coded_q <= 1'b0;
      end else begin
        out_p   <= is_pulse && pol;
        out_n   <= is_pulse && !pol;
        viol_q  <= (kind == SYM_VIOL);
        coded_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import lenc_pkg::*;
#(
  parameter int unsigned DEPTH = B8_RUN,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic tx_bit,
  input  logic rail_p_in,
  input  logic rail_n_in,
  input  logic dual_rail,
  input  logic code_ami,
  input  logic sel_t1,
  output logic line_p,
  output logic line_n
);

  // Named internal events (observed by the bound checker).
  logic          hdb_mode;
  logic          enc_adv;
  logic [IW-1:0] tap_idx;
  logic          tap_bit;
  logic          tap_vld;
  logic          win_zero;
  logic          even;
  logic          sub_start;
  logic          sub_busy;
  logic          viol_q;
  logic          coded_q;
  sym_kind_e     kind;

  assign hdb_mode = !sel_t1 && !code_ami;
  assign enc_adv  = bit_stb && !dual_rail;
  assign tap_idx  = hdb_mode ? IW'(HDB_RUN - 1) : IW'(DEPTH - 1);

  lenc_delay #(.DEPTH(DEPTH)) i_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (dual_rail),
    .shift    (enc_adv),
    .din      (tx_bit),
    .tap_idx  (tap_idx),
    .tap_bit  (tap_bit),
    .tap_vld  (tap_vld),
    .win_zero (win_zero)
  );

  lenc_subst i_subst (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (dual_rail),
    .adv       (enc_adv),
    .use_sub   (!code_ami),
    .t1        (sel_t1),
    .even      (even),
    .tap_bit   (tap_bit),
    .tap_vld   (tap_vld),
    .win_zero  (win_zero),
    .kind      (kind),
    .sub_start (sub_start),
    .sub_busy  (sub_busy)
  );

  lenc_pol i_pol (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (dual_rail),
    .adv     (bit_stb),
    .dual    (dual_rail),
    .rail_p  (rail_p_in),
    .rail_n  (rail_n_in),
    .kind    (kind),
    .even    (even),
    .out_p   (line_p),
    .out_n   (line_n),
    .viol_q  (viol_q),
    .coded_q (coded_q)
  );

endmodule

// File: rtl/lenc_chk.sv
module lenc_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic dual_rail,
  input logic rail_p_in,
  input logic rail_n_in,
  input logic hdb_mode,
  input logic line_p,
  input logic line_n,
  input logic viol_q,
  input logic coded_q
);

  logic stb_d;
  logic have_last;
  logic last_p;
  logic have_v;
  logic last_v;
  logic new_pulse;

  assign new_pulse = stb_d && coded_q && (line_p || line_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_d     <= 1'b0;
      have_last <= 1'b0;
      last_p    <= 1'b0;
      have_v    <= 1'b0;
      last_v    <= 1'b0;
    end else begin
      stb_d <= bit_stb;
      if (dual_rail || (bit_stb && !hdb_mode)) have_v <= 1'b0;
      if (dual_rail) begin
        have_last <= 1'b0;
      end else if (new_pulse) begin
        have_last <= 1'b1;
        last_p    <= line_p;
        if (viol_q && hdb_mode) begin
          have_v <= 1'b1;
          last_v <= line_p;
        end
      end
    end
  end

  // R2: rails copied through in dual-rail mode
  p_pass_dual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && dual_rail) |=> (line_p == $past(rail_p_in) && line_n == $past(rail_n_in)));

  // R7: never both rails high while coding
  p_excl_rails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    coded_q |-> !(line_p && line_n));

  // R8: no strobe, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ($stable(line_p) && $stable(line_n)));

  // R3: a repeated polarity is always a violation
  p_repeat_is_viol_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (new_pulse && have_last && (line_p == last_p) && !dual_rail) |-> viol_q);

  // R9: HDB3 violations alternate
  p_viol_alt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (new_pulse && viol_q && hdb_mode && have_v && !dual_rail) |-> (line_p != last_v));

endmodule

bind line_encoder lenc_chk i_lenc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_stb   (bit_stb),
  .dual_rail (dual_rail),
  .rail_p_in (rail_p_in),
  .rail_n_in (rail_n_in),
  .hdb_mode  (hdb_mode),
  .line_p    (line_p),
  .line_n    (line_n),
  .viol_q    (viol_q),
  .coded_q   (coded_q)
);

// File: tb/test_line_encoder.sv
`timescale 1ns/1ps
module test_line_encoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, tx_bit = 1'b0, rail_p_in = 1'b0, rail_n_in = 1'b0;
  logic dual_rail = 1'b0, code_ami = 1'b0, sel_t1 = 1'b0;
  logic line_p, line_n;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // model state
  logic  bits [0:1023];
  int    k_idx, m_rem, m_pos, m_cnt;
  logic  m_last;
  string m_pat;
  logic  exp_p, exp_n;
  // port-observed violation tracking (R9)
  logic  o_have_prev, o_prev, o_have_v, o_last_v;

  always #2 clk = ~clk;

  line_encoder i_line_encoder (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_bit(tx_bit),
    .rail_p_in(rail_p_in), .rail_n_in(rail_n_in), .dual_rail(dual_rail),
    .code_ami(code_ami), .sel_t1(sel_t1), .line_p(line_p), .line_n(line_n)
  );

  task automatic chk(input string tag, input logic ap, input logic an,
                     input logic ep, input logic en);
    total++;
    if (ap !== ep || an !== en) begin
      bad++;
      $display("FAIL %s got p=%0b n=%0b expected p=%0b n=%0b", tag, ap, an, ep, en);
    end
  endtask

  function automatic int run_len();
    return (!sel_t1 && !code_ami) ? 4 : 8;
  endfunction

  // Start a coded segment: dual-rail pulse clears state, then set mode.
  task automatic start_seg(input logic ami, input logic t1);
    @(negedge clk); dual_rail = 1'b1;
    @(negedge clk); code_ami = ami; sel_t1 = t1; dual_rail = 1'b0;
    k_idx = 0; m_rem = 0; m_pos = 0; m_cnt = 0; m_last = 1'b0;
    o_have_prev = 1'b0; o_have_v = 1'b0;
    exp_p = line_p; exp_n = line_n;
  endtask

  // Compute expected output after strobe k_idx (bit already stored).
  task automatic model_step();
    int n, j;
    byte ch;
    bit all0;
    n = run_len();
    exp_p = 1'b0; exp_n = 1'b0;
    if (k_idx < n) return;
    j = k_idx - n;
    if (m_rem > 0) begin
      ch = m_pat.getc(m_pos); m_pos++; m_rem--;
    end else begin
      all0 = 1'b1;
      for (int i = 0; i < n; i++) if (bits[j+i]) all0 = 1'b0;
      if (!code_ami && all0) begin
        if (sel_t1) m_pat = "000VB0VB";
        else        m_pat = (m_cnt % 2 == 0) ? "B00V" : "000V";
        ch = m_pat.getc(0); m_pos = 1; m_rem = n - 1;
      end else begin
        ch = bits[j] ? "1" : "0";
      end
    end
    if (ch == "V") begin
      exp_p = m_last; exp_n = !m_last; m_cnt = 0;
    end else if (ch != "0") begin
      exp_p = !m_last; exp_n = m_last; m_last = !m_last; m_cnt++;
    end
  endtask

  task automatic send_bit(input logic b, input string tag);
    @(negedge clk); tx_bit = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    bits[k_idx] = b;
    model_step();
    chk((k_idx < run_len()) ? "R6" : tag, line_p, line_n, exp_p, exp_n);
    k_idx++;
    total++;
    if (line_p && line_n) begin
      bad++; $display("FAIL R7 got p=1 n=1 expected at most one rail");
    end
    if (!sel_t1 && !code_ami && (line_p || line_n)) begin
      if (o_have_prev && line_p == o_prev) begin
        if (o_have_v) chk("R9", line_p, 1'b0, !o_last_v, 1'b0);
        o_have_v = 1'b1; o_last_v = line_p;
      end
      o_have_prev = 1'b1; o_prev = line_p;
    end
    if ($urandom % 4 == 0) begin
      @(negedge clk);
      chk("R8", line_p, line_n, exp_p, exp_n);
    end
  endtask

  task automatic rand_seg(input int nb, input string tag);
    for (int i = 0; i < nb; i++) send_bit(($urandom % 4) == 0, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0007));
    repeat (3) @(negedge clk);
    chk("R1", line_p, line_n, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", line_p, line_n, 1'b0, 1'b0);

    // R1: first mark after start goes positive (AMI, latency 8)
    start_seg(1'b1, 1'b0);
    send_bit(1'b1, "R1");
    for (int i = 0; i < 8; i++) send_bit(1'b0, "R1");
    // R5: AMI directed: ones and long zero runs
    for (int i = 0; i < 12; i++) send_bit(1'b1, "R5");
    for (int i = 0; i < 20; i++) send_bit(1'b0, "R5");
    rand_seg(150, "R5");

    // R3: HDB3 directed - all zeros (B00V then chained), then odd-parity case
    start_seg(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) send_bit(1'b0, "R3");
    send_bit(1'b1, "R3");
    for (int i = 0; i < 8; i++) send_bit(1'b0, "R3");
    send_bit(1'b1, "R3"); send_bit(1'b1, "R3");
    for (int i = 0; i < 8; i++) send_bit(1'b0, "R3");
    rand_seg(300, "R3");

    // R4: B8ZS directed and random
    start_seg(1'b0, 1'b1);
    send_bit(1'b1, "R4");
    for (int i = 0; i < 17; i++) send_bit(1'b0, "R4");
    send_bit(1'b1, "R4"); send_bit(1'b1, "R4");
    for (int i = 0; i < 9; i++) send_bit(1'b0, "R4");
    rand_seg(300, "R4");

    // R5 in T1 line mode
    start_seg(1'b1, 1'b1);
    rand_seg(120, "R5");

    // R2: dual-rail pass-through
    @(negedge clk); dual_rail = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic rp, rn;
      rp = $urandom % 2; rn = $urandom % 2;
      @(negedge clk); rail_p_in = rp; rail_n_in = rn; bit_stb = 1'b1;
      @(negedge clk); bit_stb = 1'b0;
      chk("R2", line_p, line_n, rp, rn);
    end
    // R2: state cleared - HDB3 restarts from reset polarity and parity
    start_seg(1'b0, 1'b0);
    send_bit(1'b1, "R2");
    for (int i = 0; i < 12; i++) send_bit(1'b0, "R2");
    rand_seg(100, "R3");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule